// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small 32-bit in-order processor core split into five stages: fetch, decode, execute, data-memory access and write-back. It runs four register-to-register operations (add, subtract, bitwise and, bitwise or) plus a word load and a word store. The core holds its own instruction memory and data memory. Both are filled through dedicated write ports while reset is held low.

The operation is decoded once, in the decode stage. The decoded control bits then travel with the instruction through the stage registers, and each stage register keeps only the bits that later stages still use. The execute stage takes the arithmetic function from the low six bits of the sign-extended immediate. No separate function field is carried. The register file takes a write-back value early enough that an instruction decoding in the same cycle reads the new value.

The core has no hazard detection and no forwarding. Software, here the testbench, must keep at least two unrelated instructions between a producer and its consumer. Every register write is shown on an observation port, so a sequential reference model can be compared against it one write at a time.

Top module: `pipe5_core`

## Requirements
- R1: `rst_n` is an active-low asynchronous reset. While it is low, the fetch address is 0, every stage register's control bits are zero, all registers read zero and `wb_valid` is low. After release, nothing is reported until the first instruction reaches the last stage.
- R2: Instruction fields are opcode [31:26], first source [25:21], second source/target [20:16], destination [15:11] and immediate [15:0]. Opcode 0x00 is register-to-register and writes the destination field. Opcode 0x23 is a load that writes the target field. Opcode 0x2B is a store.
- R3: For opcode 0x00, the execute stage picks the operation from bits [5:0] of the sign-extended immediate: 0x20 add, 0x22 subtract (first minus second), 0x24 and, 0x25 or. Any other code yields 0, and that 0 is still written.
- R4: A load writes the target register with data-memory word (first source + sign-extended immediate) bits [DAW+1:2].
- R5: A store writes the target register's value to that same word. A store produces no register write. A load placed directly after a store to the same word returns the stored value.
- R6: A value being written back is returned to an instruction that reads that register in decode during the same cycle. A consumer placed three slots after its producer therefore sees the new value.
- R7: Register 0 always reads as zero. Writes to it are discarded and never reported.
- R8: The instruction at word index k is reported in cycle k+4, where cycle n follows the n-th rising edge after reset release. Once the pipeline is full, one instruction completes every cycle.
- R9: Any opcode other than 0x00, 0x23 and 0x2B writes no register and no memory.
- R10: `wb_valid` is high for exactly one cycle for each completing instruction that writes a nonzero register. In that cycle `wb_rd` and `wb_data` carry the register index and the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction memory load strobe |
| imem_addr | input | IAW | Instruction memory word index to load |
| imem_wdata | input | 32 | Instruction word to load |
| dmem_we | input | 1 | Data memory load strobe (has priority over stores) |
| dmem_addr | input | DAW | Data memory word index to load |
| dmem_wdata | input | XLEN | Data word to load |
| wb_valid | output | 1 | A register write is completing this cycle |
| wb_rd | output | 5 | Register written |
| wb_data | output | XLEN | Value written |

## Verification
The bench targets the following corner cases. A producer and a consumer exactly three slots apart catch a register file that lacks the same-cycle write-then-read path; such a design would hand the consumer the stale value. A load directly behind a store to the same word catches a store that lands late. Writes aimed at register 0, unknown opcodes shaped like a store, and an unknown function code each catch leaked writes or spurious reports. Every report is also checked against its expected cycle, so a missing or extra stage register shows up as a timing error. A reset asserted while the pipeline is full must drop the report at once, and the next program must see all registers at zero.

// File: rtl/pipe5_pkg.sv
`timescale 1ns/1ps
package pipe5_pkg;

  localparam int INSN_W = 32;
  localparam int REG_AW = 5;
  localparam int IMM_W  = 16;
  localparam int FN_W   = 6;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_ZERO
  } alu_op_e;

  // execute-stage controls
  typedef struct packed {
    logic fn_from_imm;  // take operation from immediate low bits
    logic b_is_imm;     // second operand is the immediate
    logic dst_is_rd;    // destination from [15:11] instead of [20:16]
  } ex_ctl_t;

  // memory-stage controls
  typedef struct packed {
    logic rd_en;
    logic wr_en;
  } mem_ctl_t;

  // write-back-stage controls
  typedef struct packed {
    logic wr_en;
    logic from_mem;
  } wb_ctl_t;

  function automatic alu_op_e fn_to_op(input logic [FN_W-1:0] fn);
    case (fn)
      FN_ADD:  return ALU_ADD;
      FN_SUB:  return ALU_SUB;
      FN_AND:  return ALU_AND;
      FN_OR:   return ALU_OR;
      default: return ALU_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/p5_decode.sv
`timescale 1ns/1ps
module p5_decode
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  output ex_ctl_t    ex_o,
  output mem_ctl_t   mem_o,
  output wb_ctl_t    wb_o
);

  always_comb begin
    ex_o  = '0;
    mem_o = '0;
    wb_o  = '0;
    case (opcode)
      OPC_REG: begin
        ex_o.fn_from_imm = 1'b1;
        ex_o.dst_is_rd   = 1'b1;
        wb_o.wr_en       = 1'b1;
      end
      OPC_LOAD: begin
        ex_o.b_is_imm = 1'b1;
        mem_o.rd_en   = 1'b1;
        wb_o.wr_en    = 1'b1;
        wb_o.from_mem = 1'b1;
      end
      OPC_STORE: begin
        ex_o.b_is_imm = 1'b1;
        mem_o.wr_en   = 1'b1;
      end
      default: begin
        // unrecognised opcode: every control stays zero (R9)
      end
    endcase
  end

endmodule

// File: rtl/p5_alu.sv
`timescale 1ns/1ps
module p5_alu
  import pipe5_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      default: y = '0;
    endcase
  end

  always_comb begin
    if (op == ALU_SUB) begin
      assert_sub_inverts_add_R3: assert (W'(y + b) == a)
        else $error("subtract result does not invert");
    end
    if (op == ALU_AND) begin
      assert_and_within_or_R3: assert ((y & ~(a | b)) == '0)
        else $error("and result has bits outside operands");
    end
  end

endmodule

// File: rtl/p5_regfile.sv
`timescale 1ns/1ps
module p5_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  output logic [W-1:0]  rd1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd2
);

  logic [W-1:0] regs_q [1:NREG-1];
  logic         wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_live) begin
      regs_q[waddr] <= wdata;
    end
  end

  // read ports: register 0 is hardwired, and an in-flight write is
  // returned in the same cycle (write-before-read)
  always_comb begin
    if (ra1 == '0)                    rd1 = '0;
    else if (wr_live && waddr == ra1) rd1 = wdata;
    else                              rd1 = regs_q[ra1];
  end

  always_comb begin
    if (ra2 == '0)                    rd2 = '0;
    else if (wr_live && waddr == ra2) rd2 = wdata;
    else                              rd2 = regs_q[ra2];
  end

  always_comb begin
    if (rst_n && ra1 == '0 && ra2 == '0) begin
      assert_zero_reg_reads_zero_R7: assert (rd1 == '0 && rd2 == '0)
        else $error("register 0 read nonzero");
    end
    if (rst_n && wr_live && waddr == ra2) begin
      assert_write_visible_same_cycle_R6: assert (rd2 == wdata)
        else $error("write-back value not visible to decode");
    end
  end

endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 128,
  parameter int DMEM_WORDS = 64,
  localparam int IAW       = $clog2(IMEM_WORDS),
  localparam int DAW       = $clog2(DMEM_WORDS),
  localparam int NREG      = 1 << REG_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imem_we,
  input  logic [IAW-1:0]    imem_addr,
  input  logic [INSN_W-1:0] imem_wdata,
  input  logic              dmem_we,
  input  logic [DAW-1:0]    dmem_addr,
  input  logic [XLEN-1:0]   dmem_wdata,
  output logic              wb_valid,
  output logic [REG_AW-1:0] wb_rd,
  output logic [XLEN-1:0]   wb_data
);

  localparam logic [XLEN-1:0] PC_STEP = XLEN'(4);

  // ---------------------------------------------------------------- fetch
  logic [INSN_W-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0]   pc_q, pc_d;
  logic [INSN_W-1:0] fetch_insn;

  always_ff @(posedge clk) begin
    if (imem_we) imem[imem_addr] <= imem_wdata;
  end

  assign fetch_insn = imem[pc_q[IAW+1:2]];

  always_comb pc_d = pc_q + PC_STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // fetch/decode register: an all-zero word behaves as a no-op
  logic [INSN_W-1:0] ifid_insn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ifid_insn_q <= '0;
    else        ifid_insn_q <= fetch_insn;
  end

  // --------------------------------------------------------------- decode
  logic [5:0]        id_opc;
  logic [REG_AW-1:0] id_rs, id_rt, id_rd;
  logic [XLEN-1:0]   id_imm, id_a, id_b;
  ex_ctl_t           id_ex;
  mem_ctl_t          id_mem;
  wb_ctl_t           id_wb;
  logic              id_known;

  assign id_opc   = ifid_insn_q[31:26];
  assign id_rs    = ifid_insn_q[25:21];
  assign id_rt    = ifid_insn_q[20:16];
  assign id_rd    = ifid_insn_q[15:11];
  assign id_imm   = {{(XLEN-IMM_W){ifid_insn_q[IMM_W-1]}}, ifid_insn_q[IMM_W-1:0]};
  assign id_known = (id_opc == OPC_REG) || (id_opc == OPC_LOAD) || (id_opc == OPC_STORE);

  p5_decode u_decode (
    .opcode (id_opc),
    .ex_o   (id_ex),
    .mem_o  (id_mem),
    .wb_o   (id_wb)
  );

  logic              rf_we;
  logic [REG_AW-1:0] rf_waddr;
  logic [XLEN-1:0]   rf_wdata;

  p5_regfile #(.W(XLEN), .NREG(NREG)) u_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata),
    .ra1   (id_rs),
    .rd1   (id_a),
    .ra2   (id_rt),
    .rd2   (id_b)
  );

  // decode/execute register
  ex_ctl_t           idex_ex_q;
  mem_ctl_t          idex_mem_q;
  wb_ctl_t           idex_wb_q;
  logic [XLEN-1:0]   idex_a_q, idex_b_q, idex_imm_q;
  logic [REG_AW-1:0] idex_rt_q, idex_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idex_ex_q  <= '0;
      idex_mem_q <= '0;
      idex_wb_q  <= '0;
    end else begin
      idex_ex_q  <= id_ex;
      idex_mem_q <= id_mem;
      idex_wb_q  <= id_wb;
    end
  end

  always_ff @(posedge clk) begin
    idex_a_q   <= id_a;
    idex_b_q   <= id_b;
    idex_imm_q <= id_imm;
    idex_rt_q  <= id_rt;
    idex_rd_q  <= id_rd;
  end

  // -------------------------------------------------------------- execute
  alu_op_e           ex_op;
  logic [XLEN-1:0]   ex_opb, ex_res;
  logic [REG_AW-1:0] ex_dst;

  always_comb begin
    ex_op  = idex_ex_q.fn_from_imm ? fn_to_op(idex_imm_q[FN_W-1:0]) : ALU_ADD;
    ex_opb = idex_ex_q.b_is_imm ? idex_imm_q : idex_b_q;
    ex_dst = idex_ex_q.dst_is_rd ? idex_rd_q : idex_rt_q;
  end

  p5_alu #(.W(XLEN)) u_alu (
    .op (ex_op),
    .a  (idex_a_q),
    .b  (ex_opb),
    .y  (ex_res)
  );

  // execute/memory register
  mem_ctl_t          exmem_mem_q;
  wb_ctl_t           exmem_wb_q;
  logic [XLEN-1:0]   exmem_res_q, exmem_store_q;
  logic [REG_AW-1:0] exmem_dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exmem_mem_q <= '0;
      exmem_wb_q  <= '0;
    end else begin
      exmem_mem_q <= idex_mem_q;
      exmem_wb_q  <= idex_wb_q;
    end
  end

  always_ff @(posedge clk) begin
    exmem_res_q   <= ex_res;
    exmem_store_q <= idex_b_q;
    exmem_dst_q   <= ex_dst;
  end

  // --------------------------------------------------------------- memory
  logic [XLEN-1:0] dmem [DMEM_WORDS];
  logic [DAW-1:0]  mem_idx;
  logic [XLEN-1:0] mem_rdata;

  assign mem_idx = exmem_res_q[DAW+1:2];

  always_ff @(posedge clk) begin
    if (dmem_we)                dmem[dmem_addr] <= dmem_wdata;
    else if (exmem_mem_q.wr_en) dmem[mem_idx]   <= exmem_store_q;
  end

  always_comb mem_rdata = exmem_mem_q.rd_en ? dmem[mem_idx] : '0;

  // memory/write-back register
  wb_ctl_t           memwb_wb_q;
  logic [XLEN-1:0]   memwb_res_q, memwb_ld_q;
  logic [REG_AW-1:0] memwb_dst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) memwb_wb_q <= '0;
    else        memwb_wb_q <= exmem_wb_q;
  end

  always_ff @(posedge clk) begin
    memwb_res_q <= exmem_res_q;
    memwb_ld_q  <= mem_rdata;
    memwb_dst_q <= exmem_dst_q;
  end

  // ----------------------------------------------------------- write-back
  always_comb begin
    rf_we    = memwb_wb_q.wr_en && (memwb_dst_q != '0);
    rf_waddr = memwb_dst_q;
    rf_wdata = memwb_wb_q.from_mem ? memwb_ld_q : memwb_res_q;
  end

  assign wb_valid = rf_we;
  assign wb_rd    = rf_waddr;
  assign wb_data  = rf_wdata;

  // ----------------------------------------------------------- assertions
  assert_fetch_advances_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pc_q == $past(pc_q) + PC_STEP)
    else $error("fetch address did not step by one word");

  assert_store_never_reported_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_mem_q.wr_en |=> !wb_valid)
    else $error("store produced a register write-back");

  assert_report_needs_write_ctl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(exmem_wb_q.wr_en))
    else $error("write-back without a write control one stage earlier");

  assert_unknown_op_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !id_known |=> (idex_mem_q == '0) && (idex_wb_q == '0))
    else $error("unknown opcode carried live controls");

endmodule

// File: tb/pipe5_core_bench.sv
`timescale 1ns/1ps
module pipe5_core_bench;

  localparam int IW  = 128;
  localparam int DW  = 64;
  localparam int IAW = 7;
  localparam int DAW = 6;
  localparam int MAXE = 256;

  localparam logic [5:0] O_REG = 6'h00, O_LD = 6'h23, O_ST = 6'h2B;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24, F_OR = 6'h25;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            imem_we = 1'b0;
  logic [IAW-1:0]  imem_addr = '0;
  logic [31:0]     imem_wdata = '0;
  logic            dmem_we = 1'b0;
  logic [DAW-1:0]  dmem_addr = '0;
  logic [31:0]     dmem_wdata = '0;
  logic            wb_valid;
  logic [4:0]      wb_rd;
  logic [31:0]     wb_data;

  always #2 clk = ~clk;  // 250 MHz

  pipe5_core #(.XLEN(32), .IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_pipe5_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_we    (imem_we),
    .imem_addr  (imem_addr),
    .imem_wdata (imem_wdata),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .wb_valid   (wb_valid),
    .wb_rd      (wb_rd),
    .wb_data    (wb_data)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] prog [IW];
  int          prog_len;
  logic [31:0] init_mem [DW];

  logic [31:0] m_reg [32];
  logic [31:0] m_mem [DW];
  int          exp_n;
  logic [4:0]  exp_rd   [MAXE];
  logic [31:0] exp_data [MAXE];
  int          exp_cyc  [MAXE];
  string       exp_tag  [MAXE];

  int got_n;
  int cyc;
  bit running = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
    return {O_REG, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // sequential reference model built from the requirements
  task automatic build_expect();
    for (int r = 0; r < 32; r++) m_reg[r] = '0;
    for (int w = 0; w < DW; w++) m_mem[w] = init_mem[w];
    exp_n = 0;
    for (int k = 0; k < prog_len; k++) begin
      logic [31:0] w, a, b, imm, addr, res;
      int idx, dst;
      bit wr;
      string tag;
      w    = prog[k];
      a    = m_reg[w[25:21]];
      b    = m_reg[w[20:16]];
      imm  = {{16{w[15]}}, w[15:0]};
      addr = a + imm;
      idx  = int'((addr >> 2) % DW);
      wr   = 1'b0;
      dst  = 0;
      res  = '0;
      tag  = "R2";
      case (w[31:26])
        O_REG: begin
          wr = 1'b1; dst = int'(w[15:11]); tag = "R3";
          case (w[5:0])
            F_ADD:   res = a + b;
            F_SUB:   res = a - b;
            F_AND:   res = a & b;
            F_OR:    res = a | b;
            default: res = '0;
          endcase
        end
        O_LD: begin
          wr = 1'b1; dst = int'(w[20:16]); res = m_mem[idx]; tag = "R4";
        end
        O_ST: m_mem[idx] = b;
        default: ;
      endcase
      if (wr && dst != 0) begin
        m_reg[dst]       = res;
        exp_rd[exp_n]    = 5'(dst);
        exp_data[exp_n]  = res;
        exp_cyc[exp_n]   = k + 4;
        exp_tag[exp_n]   = tag;
        exp_n++;
      end
    end
  endtask

  // monitor: compares every write-back against the model, away from the edge
  always @(negedge clk) begin
    if (running) begin
      cyc++;
      if (wb_valid) begin
        if (got_n >= exp_n) begin
          chk(1'b0, "R10", "unexpected write-back", {27'd0, wb_rd}, 32'd0);
        end else begin
          chk(wb_rd == exp_rd[got_n], exp_tag[got_n], "dest register",
              {27'd0, wb_rd}, {27'd0, exp_rd[got_n]});
          chk(wb_data == exp_data[got_n], exp_tag[got_n], "write-back data",
              wb_data, exp_data[got_n]);
          chk(cyc == exp_cyc[got_n], "R8", "completion cycle",
              32'(cyc), 32'(exp_cyc[got_n]));
        end
        got_n++;
      end
    end
  end

  // loads both memories under reset, then runs; cut_at>0 resets mid-run
  task automatic run_prog(input int cut_at);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < IW; i++) begin
      imem_we = 1'b1; imem_addr = IAW'(i);
      imem_wdata = (i < prog_len) ? prog[i] : 32'd0;
      @(negedge clk);
    end
    imem_we = 1'b0;
    for (int i = 0; i < DW; i++) begin
      dmem_we = 1'b1; dmem_addr = DAW'(i); dmem_wdata = init_mem[i];
      @(negedge clk);
    end
    dmem_we = 1'b0;
    chk(wb_valid == 1'b0, "R1", "write-back during reset", {31'd0, wb_valid}, 32'd0);
    build_expect();
    got_n = 0;
    cyc   = 0;
    #1;
    rst_n   = 1'b1;
    running = 1'b1;
    if (cut_at > 0) begin
      repeat (cut_at) @(negedge clk);
      chk(wb_valid == 1'b1, "R8", "pipeline full before reset", {31'd0, wb_valid}, 32'd1);
      #1;
      rst_n = 1'b0;
      #1;
      chk(wb_valid == 1'b0, "R1", "write-back cleared by async reset", {31'd0, wb_valid}, 32'd0);
      running = 1'b0;
    end else begin
      repeat (prog_len + 8) @(negedge clk);
      #1;
      running = 1'b0;
      chk(got_n == exp_n, "R10", "write-back count", 32'(got_n), 32'(exp_n));
    end
  endtask

  task automatic load_directed();
    for (int w = 0; w < DW; w++) init_mem[w] = 32'h9E37_79B9 * 32'(w + 1);
    prog[0]  = enc_i(O_LD, 1, 0, 16'd0);
    prog[1]  = enc_i(O_LD, 2, 0, 16'd4);
    prog[2]  = enc_i(O_LD, 3, 0, 16'd8);
    prog[3]  = enc_i(O_LD, 4, 0, 16'd12);
    prog[4]  = 32'd0;
    prog[5]  = 32'd0;
    prog[6]  = enc_r(F_ADD, 5, 1, 2);      // back-to-back completions, R8
    prog[7]  = enc_r(F_SUB, 6, 1, 2);
    prog[8]  = enc_r(F_AND, 7, 3, 4);
    prog[9]  = enc_r(F_OR,  8, 3, 4);
    prog[10] = enc_r(F_SUB, 9, 2, 1);
    prog[11] = enc_r(F_ADD, 0, 1, 2);      // R7: discarded, not reported
    prog[12] = enc_i(6'h2A, 5, 0, 16'd24); // R9: store-shaped unknown op
    prog[13] = enc_i(6'h08, 10, 0, 16'd4); // R9: no register write
    prog[14] = enc_r(6'h27, 11, 1, 2);     // R3: unknown function writes 0
    prog[15] = enc_i(O_ST, 5, 0, 16'd16);  // R5: store
    prog[16] = enc_i(O_LD, 12, 0, 16'd16); // R5: load right behind it
    prog[17] = enc_i(O_LD, 13, 0, 16'd24); // R9: word 6 untouched
    prog[18] = enc_r(F_ADD, 14, 0, 1);     // R7: register 0 reads zero
    prog[19] = enc_i(O_LD, 15, 0, 16'hFFFC); // R4: negative offset wraps
    prog[20] = 32'd0;
    prog[21] = 32'd0;
    prog[22] = enc_r(F_ADD, 16, 15, 15);   // R6: consumer three slots later
    prog_len = 23;
  endtask

  task automatic load_random();
    int k;
    for (int w = 0; w < DW; w++) init_mem[w] = $urandom;
    k = 0;
    for (int j = 0; j < 4; j++) begin
      prog[k] = enc_i(O_LD, 1 + int'($urandom % 31), 0, 16'(4 * ($urandom % DW)));
      k++;
    end
    prog[k] = 32'd0; k++;
    prog[k] = 32'd0; k++;
    for (int j = 0; j < 18; j++) begin
      int sel, rd, rs, rt;
      logic [15:0] off;
      sel = int'($urandom % 6);
      rd  = int'($urandom % 32);
      rs  = int'($urandom % 32);
      rt  = int'($urandom % 32);
      off = ($urandom % 2 == 0) ? 16'(4 * ($urandom % DW)) : 16'(-(4 * int'($urandom % DW)));
      case (sel)
        0: prog[k] = enc_i(O_LD, rt, 0, off);
        1: prog[k] = enc_i(O_ST, rt, 0, off);
        2: prog[k] = enc_r(F_ADD, rd, rs, rt);
        3: prog[k] = enc_r(F_SUB, rd, rs, rt);
        4: prog[k] = enc_r(F_AND, rd, rs, rt);
        default: prog[k] = enc_r(F_OR, rd, rs, rt);
      endcase
      k++;
      prog[k] = 32'd0; k++;
      prog[k] = 32'd0; k++;
    end
    prog_len = k;
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(wb_valid == 1'b0, "R1", "write-back at start of reset", {31'd0, wb_valid}, 32'd0);

    load_directed();
    run_prog(0);

    // R1: registers cleared by reset; reads of unwritten registers give 0
    prog[0]  = enc_r(F_ADD, 3, 1, 2);
    prog[1]  = enc_r(F_OR, 4, 5, 16);
    prog_len = 2;
    run_prog(0);

    load_directed();
    run_prog(10);

    for (int p = 0; p < 6; p++) begin
      load_random();
      run_prog(0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule